// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator with Set/Clear Control

This block generates several independent pulse-width modulated outputs. The channel count is a parameter: 4 by default, at most 32. Each channel has a counter that advances on a selectable time base. The time base is either every clock cycle or one of two external enable pulses, `tick_a` and `tick_b`. The output is active while the counter is below the channel's duty value. A channel runs left-aligned, counting up and wrapping, or center-aligned, counting up and then back down.

Software controls the block through a word-addressed register bank.

- **Global registers.** Channel enables and interrupt mask bits are changed only by write-one-to-set and write-one-to-clear strobes. Each has its own readback register.
- **Pending flags.** Every enabled channel raises a pending flag at the end of each of its periods. Reading the status register returns these flags and clears them in the same access.
- **Interrupt.** One combined interrupt line reports any pending channel whose mask bit is set.
- **Duty changes.** A duty value written to a running channel waits for the next period boundary, so a running waveform never shows a torn period.

Top module: `pwm_bank_ctrl`

## Requirements
- R1: A write to offset 0x04 enables every channel whose data bit is one. A write to 0x08 disables every channel whose data bit is one. Zero bits change nothing. Offset 0x0C reads the enabled set, with bit n for channel n.
- R2: A write to 0x10 sets interrupt-mask bits wherever the data holds a one. A write to 0x14 clears them. Zero bits change nothing. Offset 0x18 reads the mask.
- R3: A read of 0x1C returns the pending flags and clears them. A period end in the same cycle as that read stays pending for the next read.
- R4: An enabled channel sets its pending flag once per period, at its last tick. A disabled channel never sets it.
- R5: The `irq` output is one exactly while some channel is both pending and masked in.
- R6: Channel n's bank starts at 0x200 + n*0x20. It holds mode at +0x00, duty at +0x04, period at +0x08 and a read-only counter at +0x0C. Mode bits [1:0] select the time base: 0 or 3 for every clock, 1 for `tick_a`, 2 for `tick_b`. Bit 2 selects center alignment. Bit 3 inverts the output.
- R7: In left-aligned mode with period P >= 1, the counter runs 0 to P-1. A period lasts P ticks, and the uninverted output is high for min(D, P) ticks of it.
- R8: In center-aligned mode with P >= 1, a period lasts 2P ticks. The uninverted output is high for 0 ticks when D = 0, for 2D-1 ticks when 1 <= D <= P, and for 2P ticks when D > P.
- R9: A channel's counter advances only on ticks of its selected time base. Pulses on the other enable input leave it unchanged.
- R10: A duty write to an enabled channel takes effect at its next period end. A disabled channel adopts a written duty at once.
- R11: Disabling a channel returns its counter to 0 and drives its output to the inactive level. The inactive level is 0, or 1 when bit 3 of the mode is set.
- R12: Read data appears on `bus_rdata` in the cycle after the read access and holds until the next read. A register write takes effect at the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the every-cycle time base |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| tick_a | input | 1 | Time-base enable pulse A |
| tick_b | input | 1 | Time-base enable pulse B |
| pwm_out | output | NCH | One modulated output per channel |
| irq | output | 1 | Combined interrupt |

## Verification
A write acts at the sampling edge. Enable, mask and pending state, and the outputs that depend on them, can therefore be seen at the following falling edge, where the bench samples. Read data is registered: the bench launches a read at one falling edge and compares `bus_rdata` at the next. A status read shows the pending state from before its own edge, so a tick pulse driven in the same cycle must show up only on the following read.

Pulse-width checks count high samples over exactly two whole periods, in cycles. That count is the same whatever the phase at which counting starts. Counter and pending checks use the external tick pulses, so every counter value is known exactly when it is read back.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;

    // global register byte offsets
    localparam logic [ADDR_W-1:0] OFS_EN_SET  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR  = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_EN_RD   = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_MSK_SET = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_MSK_CLR = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_MSK_RD  = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_STAT    = 12'h01C;

    // channel banks
    localparam logic [ADDR_W-1:0] CH_BASE  = 12'h200;
    localparam int                CH_SHIFT = 5;   // 0x20 stride

    // word index inside a channel bank
    typedef enum logic [2:0] {
        CR_MODE = 3'd0,
        CR_DUTY = 3'd1,
        CR_PRD  = 3'd2,
        CR_CNT  = 3'd3
    } chan_reg_e;

    typedef enum logic [1:0] {
        TB_CLK  = 2'd0,
        TB_A    = 2'd1,
        TB_B    = 2'd2,
        TB_CLK2 = 2'd3
    } tbase_e;

    // mode word layout, low bits upward: tbase[1:0], center[2], invert[3]
    typedef struct packed {
        logic   invert;
        logic   center;
        tbase_e tbase;
    } chan_mode_t;

    localparam int MODE_W = $bits(chan_mode_t);

    function automatic logic pick_tick(tbase_e tb, logic ta, logic tbb);
        case (tb)
            TB_A:    return ta;
            TB_B:    return tbb;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/pwmc_chan.sv
module pwmc_chan #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          tick,
    input  logic          center,
    input  logic          invert,
    input  logic [CW-1:0] prd,
    input  logic [CW-1:0] duty,
    output logic [CW-1:0] cnt,
    output logic          prd_end,
    output logic          pwm
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] duty_act;
    logic          down_q;
    logic [CW:0]   cnt_inc;
    logic          reach_top;
    logic          at_floor;
    logic          wrap_evt;

    assign cnt_inc   = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
    assign reach_top = cnt_inc >= {1'b0, prd};
    assign at_floor  = cnt_q <= CW'(1);
    assign wrap_evt  = center ? (down_q && at_floor) : reach_top;
    assign prd_end   = en && tick && wrap_evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            down_q   <= 1'b0;
            duty_act <= '0;
        end else if (!en) begin
            cnt_q    <= '0;
            down_q   <= 1'b0;
            duty_act <= duty;
        end else if (tick) begin
            if (center) begin
                if (!down_q) begin
                    cnt_q <= cnt_inc[CW-1:0];
                    if (reach_top) down_q <= 1'b1;
                end else if (at_floor) begin
                    cnt_q  <= '0;
                    down_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - CW'(1);
                end
            end else begin
                down_q <= 1'b0;
                cnt_q  <= reach_top ? '0 : cnt_inc[CW-1:0];
            end
            if (wrap_evt) duty_act <= duty;
        end
    end

    assign cnt = cnt_q;
    assign pwm = (en && (cnt_q < duty_act)) ^ invert;

    // R11: a disabled channel sits at zero, counting up
    a_r11_off_clears: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt_q == '0) && !down_q);

    // R10: the active duty only moves at a period end or while disabled
    a_r10_duty_held: assert property (@(posedge clk) disable iff (rst)
        (en && !prd_end) |=> (duty_act == $past(duty_act)));

    // R9: without a tick an enabled counter holds
    a_r9_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/pwmc_glob.sv
module pwmc_glob #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] en_set,
    input  logic [NCH-1:0] en_clr,
    input  logic [NCH-1:0] msk_set,
    input  logic [NCH-1:0] msk_clr,
    input  logic           stat_rd,
    input  logic [NCH-1:0] prd_end,
    output logic [NCH-1:0] en_q,
    output logic [NCH-1:0] msk_q,
    output logic [NCH-1:0] pend_q,
    output logic           irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            msk_q  <= '0;
            pend_q <= '0;
        end else begin
            en_q   <= (en_q  | en_set)  & ~en_clr;
            msk_q  <= (msk_q | msk_set) & ~msk_clr;
            pend_q <= (stat_rd ? '0 : pend_q) | prd_end;
        end
    end

    assign irq = |(pend_q & msk_q);

    // R1: set strobe bits land in the enable register
    a_r1_en_set: assert property (@(posedge clk) disable iff (rst)
        (|en_set) |=> ((en_q & $past(en_set)) == $past(en_set)));

    // R1: clear strobe bits leave the enable register
    a_r1_en_clr: assert property (@(posedge clk) disable iff (rst)
        (|en_clr) |=> ((en_q & $past(en_clr)) == '0));

    // R2: mask clear strobe
    a_r2_msk_clr: assert property (@(posedge clk) disable iff (rst)
        (|msk_clr) |=> ((msk_q & $past(msk_clr)) == '0));

    // R3: a status read leaves only same-cycle events pending
    a_r3_read_clears: assert property (@(posedge clk) disable iff (rst)
        stat_rd |=> ((pend_q & ~$past(prd_end)) == '0));

    // R3: pending bits are sticky without a read
    a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
        !stat_rd |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R4: a disabled channel never reports a period end
    a_r4_off_quiet: assert property (@(posedge clk) disable iff (rst)
        ((prd_end & ~en_q) == '0));

endmodule

// File: rtl/pwm_bank_ctrl.sv
module pwm_bank_ctrl
    import pwmc_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_a,
    input  logic              tick_b,
    output logic [NCH-1:0]    pwm_out,
    output logic              irq
);

    localparam int SLOT_W = ADDR_W - CH_SHIFT;

    logic                wr_go;
    logic                rd_go;
    logic [SLOT_W-1:0]   ch_slot;
    logic                ch_hit;
    chan_reg_e           reg_sel;

    logic [NCH-1:0]      en_set, en_clr, msk_set, msk_clr;
    logic                stat_rd;
    logic [NCH-1:0]      en_q, msk_q, pend_q, prd_end;

    chan_mode_t          mode_q [NCH];
    logic [CW-1:0]       duty_q [NCH];
    logic [CW-1:0]       prd_q  [NCH];
    logic [CW-1:0]       cnt_w  [NCH];

    logic [DATA_W-1:0]   rd_word;
    logic                unused_bits;

    // upper data bits beyond the widest field carry no meaning
    assign unused_bits = ^bus_wdata;

    assign wr_go   = bus_sel && bus_wr;
    assign rd_go   = bus_sel && !bus_wr;
    assign ch_slot = SLOT_W'((bus_addr - CH_BASE) >> CH_SHIFT);
    assign ch_hit  = (bus_addr >= CH_BASE) && (32'(ch_slot) < NCH);
    assign reg_sel = chan_reg_e'(bus_addr[4:2]);

    assign en_set  = (wr_go && bus_addr == OFS_EN_SET)  ? bus_wdata[NCH-1:0] : '0;
    assign en_clr  = (wr_go && bus_addr == OFS_EN_CLR)  ? bus_wdata[NCH-1:0] : '0;
    assign msk_set = (wr_go && bus_addr == OFS_MSK_SET) ? bus_wdata[NCH-1:0] : '0;
    assign msk_clr = (wr_go && bus_addr == OFS_MSK_CLR) ? bus_wdata[NCH-1:0] : '0;
    assign stat_rd = rd_go && (bus_addr == OFS_STAT);

    pwmc_glob #(.NCH(NCH)) u_glob (
        .clk     (clk),
        .rst     (rst),
        .en_set  (en_set),
        .en_clr  (en_clr),
        .msk_set (msk_set),
        .msk_clr (msk_clr),
        .stat_rd (stat_rd),
        .prd_end (prd_end),
        .en_q    (en_q),
        .msk_q   (msk_q),
        .pend_q  (pend_q),
        .irq     (irq)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic wr_here;
        logic tick_sel;

        assign wr_here  = wr_go && ch_hit && (32'(ch_slot) == c);
        assign tick_sel = pick_tick(mode_q[c].tbase, tick_a, tick_b);

        always_ff @(posedge clk) begin
            if (rst) begin
                mode_q[c] <= '0;
                duty_q[c] <= '0;
                prd_q[c]  <= '0;
            end else if (wr_here) begin
                case (reg_sel)
                    CR_MODE: mode_q[c] <= chan_mode_t'(bus_wdata[MODE_W-1:0]);
                    CR_DUTY: duty_q[c] <= bus_wdata[CW-1:0];
                    CR_PRD:  prd_q[c]  <= bus_wdata[CW-1:0];
                    default: ;
                endcase
            end
        end

        pwmc_chan #(.CW(CW)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .en      (en_q[c]),
            .tick    (tick_sel),
            .center  (mode_q[c].center),
            .invert  (mode_q[c].invert),
            .prd     (prd_q[c]),
            .duty    (duty_q[c]),
            .cnt     (cnt_w[c]),
            .prd_end (prd_end[c]),
            .pwm     (pwm_out[c])
        );

        // R6: the counter word cannot be written
        a_r6_cnt_readonly: assert property (@(posedge clk) disable iff (rst)
            (wr_here && reg_sel == CR_CNT) |=> ($stable(mode_q[c]) && $stable(duty_q[c])
                                                && $stable(prd_q[c])));
    end

    always_comb begin
        rd_word = '0;
        if (ch_hit) begin
            for (int c = 0; c < NCH; c++) begin
                if (32'(ch_slot) == c) begin
                    case (reg_sel)
                        CR_MODE: rd_word = DATA_W'(mode_q[c]);
                        CR_DUTY: rd_word = DATA_W'(duty_q[c]);
                        CR_PRD:  rd_word = DATA_W'(prd_q[c]);
                        CR_CNT:  rd_word = DATA_W'(cnt_w[c]);
                        default: rd_word = '0;
                    endcase
                end
            end
        end else begin
            case (bus_addr)
                OFS_EN_RD:  rd_word = DATA_W'(en_q);
                OFS_MSK_RD: rd_word = DATA_W'(msk_q);
                OFS_STAT:   rd_word = DATA_W'(pend_q);
                default:    rd_word = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        bus_rdata <= '0;
        else if (rd_go) bus_rdata <= rd_word;
    end

    // R12: read data holds between reads
    a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_go |=> $stable(bus_rdata));

    // R5: no interrupt while the mask is empty
    a_r5_no_mask_no_irq: assert property (@(posedge clk) disable iff (rst)
        (msk_q == '0) |-> !irq);

endmodule

// File: tb/tb_pwm_bank_ctrl.sv
`timescale 1ns/1ps
module tb_pwm_bank_ctrl;

    localparam int NCH = 4;
    localparam int CW  = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_sel = 1'b0;
    logic            bus_wr = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            tick_a = 1'b0;
    logic            tick_b = 1'b0;
    logic [NCH-1:0]  pwm_out;
    logic            irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    pwm_bank_ctrl #(.NCH(NCH), .CW(CW)) dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_a    (tick_a),
        .tick_b    (tick_b),
        .pwm_out   (pwm_out),
        .irq       (irq)
    );

    function automatic logic [11:0] cadr(int ch, int w);
        return 12'(12'h200 + ch * 32 + w * 4);
    endfunction

    task automatic check(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse_a(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_a = 1'b1;
            @(negedge clk); tick_a = 1'b0;
        end
    endtask

    task automatic count_high(int ch, int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[ch]) hi++;
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int hi, exp, len;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        rd(12'h00C, d); check("R1 reset enables", d, 0);
        rd(12'h018, d); check("R2 reset mask", d, 0);
        check("R5 reset irq", irq, 0);
        check("R11 reset outputs", pwm_out, 0);

        // R1 set/clear/readback
        wr(12'h004, 32'h5);
        rd(12'h00C, d); check("R1 set", d, 5);
        wr(12'h004, 32'h0);
        rd(12'h00C, d); check("R1 zero write", d, 5);
        wr(12'h008, 32'h4);
        rd(12'h00C, d); check("R1 clear", d, 1);
        wr(12'h008, 32'hF);
        rd(12'h00C, d); check("R1 clear all", d, 0);

        // R2
        wr(12'h010, 32'hA);
        rd(12'h018, d); check("R2 set", d, 10);
        wr(12'h014, 32'h0);
        rd(12'h018, d); check("R2 zero write", d, 10);
        wr(12'h014, 32'h8);
        rd(12'h018, d); check("R2 clear", d, 2);
        wr(12'h014, 32'hF);

        // R6 bank layout readback and read-only counter
        wr(cadr(2, 0), 32'hD);
        wr(cadr(2, 1), 32'h1234);
        wr(cadr(2, 2), 32'h0777);
        wr(cadr(2, 3), 32'h55);
        rd(cadr(2, 0), d); check("R6 mode", d, 13);
        rd(cadr(2, 1), d); check("R6 duty", d, 32'h1234);
        rd(cadr(2, 2), d); check("R6 period", d, 32'h0777);
        rd(cadr(2, 3), d); check("R6 counter read-only", d, 0);
        wr(cadr(2, 0), 32'h0);

        // R7 / R8 sweep
        for (int cm = 0; cm < 2; cm++) begin
            for (int p = 1; p <= 5; p++) begin
                for (int du = 0; du <= p + 1; du++) begin
                    int ch;
                    ch = (p + du) % NCH;
                    wr(12'h008, 32'(1 << ch));
                    wr(cadr(ch, 0), 32'(cm << 2));
                    wr(cadr(ch, 2), 32'(p));
                    wr(cadr(ch, 1), 32'(du));
                    wr(12'h004, 32'(1 << ch));
                    len = (cm == 1) ? 2 * p : p;
                    count_high(ch, 2 * len, hi);
                    if (cm == 0) begin
                        exp = 2 * ((du < p) ? du : p);
                        check("R7 left duty", hi, exp);
                    end else begin
                        exp = (du == 0) ? 0 : (du > p) ? 2 * p : 2 * du - 1;
                        check("R8 center duty", hi, 2 * exp);
                    end
                    wr(12'h008, 32'(1 << ch));
                end
            end
        end
        rd(12'h01C, d);

        // R9 time base selection
        wr(cadr(1, 0), 32'h1);
        wr(cadr(1, 2), 32'd100);
        wr(cadr(1, 1), 32'd0);
        wr(12'h004, 32'h2);
        pulse_a(5);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); tick_b = 1'b1;
            @(negedge clk); tick_b = 1'b0;
        end
        rd(cadr(1, 3), d); check("R9 counter on tick_a only", d, 5);

        // R11 disable clears counter; inverted output idles high
        wr(12'h008, 32'h2);
        rd(cadr(1, 3), d); check("R11 counter cleared", d, 0);
        wr(cadr(3, 0), 32'h8);
        wr(cadr(3, 2), 32'd4);
        wr(cadr(3, 1), 32'd2);
        wr(12'h004, 32'h8);
        repeat (7) @(negedge clk);
        wr(12'h008, 32'h8);
        check("R11 inverted idle level", pwm_out[3], 1);
        wr(cadr(3, 0), 32'h0);
        @(negedge clk);
        check("R11 plain idle level", pwm_out[3], 0);

        // R4 / R3 / R5 pending via tick_a, period 3
        rd(12'h01C, d);
        wr(cadr(1, 2), 32'd3);
        wr(12'h010, 32'h2);
        wr(12'h004, 32'h2);
        pulse_a(2);
        rd(12'h01C, d); check("R4 no flag mid period", d, 0);
        check("R5 irq low", irq, 0);
        pulse_a(1);
        check("R5 irq high", irq, 1);
        rd(12'h01C, d); check("R4 flag at period end", d, 2);
        check("R5 irq after read", irq, 0);
        rd(12'h01C, d); check("R3 cleared by read", d, 0);
        pulse_a(2);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h01C; tick_a = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; tick_a = 1'b0;
        check("R3 read returns old flags", bus_rdata, 0);
        rd(12'h01C, d); check("R3 same-cycle event kept", d, 2);
        pulse_a(3);
        wr(12'h014, 32'h2);
        check("R5 masked out", irq, 0);
        rd(12'h01C, d); check("R4 second period flag", d, 2);
        wr(12'h008, 32'h2);
        pulse_a(6);
        rd(12'h01C, d); check("R4 disabled no flag", d, 0);

        // R10 deferred duty
        wr(cadr(0, 0), 32'h1);
        wr(cadr(0, 2), 32'd8);
        wr(cadr(0, 1), 32'd2);
        wr(12'h004, 32'h1);
        @(negedge clk);
        check("R10 loaded while off", pwm_out[0], 1);
        pulse_a(3);
        check("R10 low past duty", pwm_out[0], 0);
        wr(cadr(0, 1), 32'd6);
        @(negedge clk);
        check("R10 new duty waits", pwm_out[0], 0);
        pulse_a(5);
        pulse_a(5);
        check("R10 new duty after boundary", pwm_out[0], 1);
        wr(12'h008, 32'h1);

        // R12 read data holds
        rd(12'h018, d);
        repeat (3) @(negedge clk);
        check("R12 rdata hold", bus_rdata, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule